// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address from a processor into a physical address by reading one entry of a flat page table kept in physical memory. The processor offers a virtual address and an access kind (read or write) through a valid/ready handshake. A table base input gives the byte address where the table starts. The block fetches the entry for the page through a one-word memory read port. It then answers with either a physical address or a fault code.

The virtual address has two parts: a page number in its upper bits and an in-page offset in its low bits. The offset width is log2 of the page size, which defaults to 4 KiB, giving 12 bits. Each entry is 64 bits by default and uses this layout:

| Bits | Meaning |
|------|---------|
| bit 0 | present |
| bit 1 | write allowed |
| bit 2 | modified (dirty) |
| bits 31:12 | physical page number |

An entry that is not present produces a page fault. A write to an entry without write permission produces a protection fault. A permitted write to an entry that is not yet marked modified first stores the entry back with the modified bit set, and only then returns its answer. The block handles a single request at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and neither mem_rd_req nor mem_wr_req is asserted.
- R2: Each accepted request issues exactly one memory read. The read goes to table_base + page_number * 8, where page_number is req_va[31:12].
- R3: On a translation, rsp_fault is 2'b00. rsp_pa is the entry's bits 31:12 in its upper 20 bits, followed by req_va[11:0] unchanged.
- R4: If the entry's bit 0 is 0, the response carries rsp_fault = 2'b01 and rsp_va equal to the faulting virtual address. No memory write is made.
- R5: A write request to a present entry whose bit 1 is 0 gets rsp_fault = 2'b10, and no memory write is made. A read request to the same entry translates normally.
- R6: A write request to a present, writable entry whose bit 2 is 0 writes the entry back to the same table address with bit 2 set and every other bit unchanged. rsp_valid rises only after mem_wr_done.
- R7: A read hit, or a write hit on an entry whose bit 2 is already 1, makes no memory write.
- R8: req_ready stays 0 from acceptance until the response has been taken with rsp_ready. While rsp_valid is 1 and rsp_ready is 0, rsp_pa, rsp_va and rsp_fault do not change.
- R9: Suppose an access faulted and its entry is then made present. Retrying the same virtual address completes as a normal translation.
- R10: The table base is sampled when the request is accepted. A later change of table_base does not alter the address read for that request.
- R11: A request held on req_valid during the cycle in which a response is taken is not accepted in that cycle. It is accepted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| table_base | input | 32 | Byte address of the page table start |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_pa | output | 32 | Translated physical address |
| rsp_va | output | 32 | Virtual address of the request being answered |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| mem_rd_req | output | 1 | One-cycle table read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_resp_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Entry read from memory |
| mem_wr_req | output | 1 | One-cycle entry write-back strobe |
| mem_wr_addr | output | 32 | Byte address of the entry written back |
| mem_wr_data | output | 64 | Entry with the modified bit set |
| mem_wr_done | input | 1 | Write-back completed |

## Verification
Two events can coincide in one cycle: the requester takes a response, and a new request is already being presented. The bench provokes this by raising rsp_ready and req_valid on the same cycle while a response is pending. It then checks the cycle after that edge. The old response must have dropped, the block must be idle, and no new table read may have been issued yet. The held request must then be accepted one cycle later and translate correctly.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WAIT, ST_WB, ST_WBW, ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  localparam int PTE_V_BIT   = 0;
  localparam int PTE_W_BIT   = 1;
  localparam int PTE_D_BIT   = 2;
  localparam int PTE_PPN_LSB = 12;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFS_W     = 12,
  parameter int PTE_BYTES = 8
) (
  input  logic [PA_W-1:0] base,
  input  logic [VA_W-1:0] va,
  output logic [PA_W-1:0] entry_addr
);
  localparam int SHIFT = $clog2(PTE_BYTES);
  localparam int VPN_W = VA_W - OFS_W;

  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  vpn_ext;

  assign vpn        = va[VA_W-1:OFS_W];
  assign vpn_ext    = PA_W'(vpn);
  assign entry_addr = base + (vpn_ext << SHIFT);
endmodule

// File: rtl/pw_pte_judge.sv
module pw_pte_judge
  import pt_walker_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFS_W = 12,
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic [OFS_W-1:0] va_ofs,
  output fault_e           fault,
  output logic             need_wb,
  output logic [PTE_W-1:0] pte_upd,
  output logic [PA_W-1:0]  pa
);
  localparam int PPN_W = PA_W - OFS_W;

  assign pa = {pte[PTE_PPN_LSB +: PPN_W], va_ofs};

  always_comb begin
    fault   = FLT_NONE;
    need_wb = 1'b0;
    pte_upd = pte;
    if (!pte[PTE_V_BIT]) begin
      fault = FLT_PAGE;
    end else if (is_write && !pte[PTE_W_BIT]) begin
      fault = FLT_PROT;
    end else if (is_write && !pte[PTE_D_BIT]) begin
      need_wb            = 1'b1;
      pte_upd[PTE_D_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int PTE_BYTES  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PA_W-1:0]        table_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_va,
  input  logic                   req_write,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PA_W-1:0]        rsp_pa,
  output logic [VA_W-1:0]        rsp_va,
  output logic [1:0]             rsp_fault,
  output logic                   mem_rd_req,
  output logic [PA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rd_resp_valid,
  input  logic [PTE_BYTES*8-1:0] mem_rd_data,
  output logic                   mem_wr_req,
  output logic [PA_W-1:0]        mem_wr_addr,
  output logic [PTE_BYTES*8-1:0] mem_wr_data,
  input  logic                   mem_wr_done
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PTE_W = PTE_BYTES * 8;

  walk_st_e         state;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PA_W-1:0]  ea_q;
  logic [PA_W-1:0]  ea_next;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  pa_q;
  fault_e           fault_q;

  fault_e           j_fault;
  logic             j_wb;
  logic [PTE_W-1:0] j_upd;
  logic [PA_W-1:0]  j_pa;

  pw_entry_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .PTE_BYTES(PTE_BYTES)
  ) u_ea (
    .base(table_base), .va(req_va), .entry_addr(ea_next)
  );

  pw_pte_judge #(
    .PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)
  ) u_judge (
    .pte(mem_rd_data), .is_write(wr_q), .va_ofs(va_q[OFS_W-1:0]),
    .fault(j_fault), .need_wb(j_wb), .pte_upd(j_upd), .pa(j_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      ea_q    <= '0;
      pte_q   <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          ea_q  <= ea_next;
          state <= ST_RD;
        end
        ST_RD:   state <= ST_WAIT;
        ST_WAIT: if (mem_rd_resp_valid) begin
          pa_q    <= j_pa;
          fault_q <= j_fault;
          pte_q   <= j_upd;
          state   <= j_wb ? ST_WB : ST_RESP;
        end
        ST_WB:   state <= ST_WBW;
        ST_WBW:  if (mem_wr_done) state <= ST_RESP;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign mem_rd_req  = (state == ST_RD);
  assign mem_wr_req  = (state == ST_WB);
  assign rsp_valid   = (state == ST_RESP);
  assign mem_rd_addr = ea_q;
  assign mem_wr_addr = ea_q;
  assign mem_wr_data = pte_q;
  assign rsp_pa      = pa_q;
  assign rsp_va      = va_q;
  assign rsp_fault   = fault_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 12,
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [VA_W-1:0]  rsp_va,
  input logic [1:0]       rsp_fault,
  input logic             mem_rd_req,
  input logic             mem_wr_req,
  input logic [PTE_W-1:0] mem_wr_data
);
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_pa[OFS_W-1:0] == rsp_va[OFS_W-1:0]);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_va) && $stable(rsp_fault)));

  a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  a_r6_dirty_in_wb: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> mem_wr_data[2]);

  a_r6_wb_before_rsp: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |=> !rsp_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_rd_req && !mem_wr_req && !rsp_valid));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)
) u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] table_base = 32'h100;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa, rsp_va;
  logic [1:0]  rsp_fault;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_resp_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        mem_wr_req;
  logic [31:0] mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic        mem_wr_done = 1'b0;

  always #5 clk = ~clk;

  pt_walker u0 (.*);

  // memory model
  logic [63:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_idx = '0;
  logic [63:0] poke_data = '0;
  logic        rd_pend = 1'b0;
  logic [31:0] rd_addr_q = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [63:0] last_wr_data = '0;

  always @(posedge clk) begin
    mem_rd_resp_valid <= rd_pend;
    mem_rd_data       <= mem[rd_addr_q[10:3]];
    rd_pend           <= 1'b0;
    if (mem_rd_req) begin
      rd_pend      <= 1'b1;
      rd_addr_q    <= mem_rd_addr;
      last_rd_addr <= mem_rd_addr;
      rd_cnt       <= rd_cnt + 1;
    end
    mem_wr_done <= mem_wr_req;
    if (mem_wr_req) begin
      mem[mem_wr_addr[10:3]] <= mem_wr_data;
      last_wr_addr <= mem_wr_addr;
      last_wr_data <= mem_wr_data;
      wr_cnt       <= wr_cnt + 1;
    end
    if (poke_en) mem[poke_idx] <= poke_data;
  end

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [19:0] ppn, input logic v, input logic w, input logic d);
    return {32'h0, ppn, 9'h0, d, w, v};
  endfunction

  function automatic logic [31:0] ent_addr(input logic [31:0] base, input logic [31:0] va);
    return base + {9'h0, va[31:12], 3'b000};
  endfunction

  task automatic poke(input logic [31:0] addr, input logic [63:0] data);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = addr[10:3]; poke_data = data;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic issue(input logic [31:0] va, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string req);
    int k;
    k = 0;
    while (!rsp_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    if (!rsp_valid) chk({req, " response timeout"}, 0, 1);
  endtask

  task automatic take_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_rd_req", mem_rd_req, 0);
    chk("R1 mem_wr_req", mem_wr_req, 0);
    chk("R1 read count", rd_cnt, 0);
  endtask

  task automatic t_read_hit();
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    poke(ent_addr(32'h100, 32'h740b), mk_pte(20'h12345, 1, 1, 0));
    issue(32'h0000740b, 1'b0);
    wait_rsp("R3");
    chk("R3 fault", rsp_fault, 2'b00);
    chk("R3 pa", rsp_pa, 32'h1234540b);
    chk("R2 one read", rd_cnt - r0, 1);
    chk("R2 read addr", last_rd_addr, 32'h138);
    chk("R7 no write on read hit", wr_cnt - w0, 0);
    take_rsp();
  endtask

  task automatic t_page_fault_retry();
    int w0;
    w0 = wr_cnt;
    poke(ent_addr(32'h100, 32'h3abc), mk_pte(20'h0, 0, 0, 0));
    issue(32'h00003abc, 1'b1);
    wait_rsp("R4");
    chk("R4 fault code", rsp_fault, 2'b01);
    chk("R4 faulting va", rsp_va, 32'h00003abc);
    chk("R4 no write", wr_cnt - w0, 0);
    take_rsp();
    poke(ent_addr(32'h100, 32'h3abc), mk_pte(20'habcde, 1, 1, 1));
    issue(32'h00003abc, 1'b1);
    wait_rsp("R9");
    chk("R9 retry fault", rsp_fault, 2'b00);
    chk("R9 retry pa", rsp_pa, 32'habcdeabc);
    take_rsp();
  endtask

  task automatic t_protection();
    int w0;
    w0 = wr_cnt;
    poke(ent_addr(32'h100, 32'h5010), mk_pte(20'h00777, 1, 0, 0));
    issue(32'h00005010, 1'b1);
    wait_rsp("R5");
    chk("R5 fault code", rsp_fault, 2'b10);
    chk("R5 no write", wr_cnt - w0, 0);
    take_rsp();
    issue(32'h00005010, 1'b0);
    wait_rsp("R5");
    chk("R5 read allowed", rsp_fault, 2'b00);
    chk("R5 read pa", rsp_pa, 32'h00777010);
    take_rsp();
  endtask

  task automatic t_dirty_wb();
    int w0, k;
    logic [63:0] e;
    e = mk_pte(20'h0beef, 1, 1, 0);
    w0 = wr_cnt;
    poke(ent_addr(32'h100, 32'h9ff0), e);
    issue(32'h00009ff0, 1'b1);
    k = 0;
    while (!mem_wr_req && k < 20) begin
      chk("R6 no rsp before wb", rsp_valid, 0);
      @(negedge clk);
      k++;
    end
    chk("R6 rsp low at wb", rsp_valid, 0);
    wait_rsp("R6");
    chk("R6 one write", wr_cnt - w0, 1);
    chk("R6 write addr", last_wr_addr, 32'h148);
    chk("R6 write data", last_wr_data, e | 64'h4);
    chk("R6 pa", rsp_pa, 32'h0beefff0);
    take_rsp();
    issue(32'h00009ff0, 1'b1);
    wait_rsp("R7");
    chk("R7 no write when dirty", wr_cnt - w0, 1);
    chk("R7 pa", rsp_pa, 32'h0beefff0);
    take_rsp();
  endtask

  task automatic t_hold_and_overlap();
    int r0;
    logic [31:0] pa0;
    poke(ent_addr(32'h100, 32'h2004), mk_pte(20'h00222, 1, 1, 1));
    poke(ent_addr(32'h100, 32'h4008), mk_pte(20'h00444, 1, 1, 1));
    issue(32'h00002004, 1'b0);
    wait_rsp("R8");
    pa0 = rsp_pa;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R8 rsp still valid", rsp_valid, 1);
    chk("R8 pa stable", rsp_pa, pa0);
    chk("R8 ready low", req_ready, 0);
    r0 = rd_cnt;
    rsp_ready = 1'b1; req_valid = 1'b1; req_va = 32'h00004008; req_write = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 rsp dropped", rsp_valid, 0);
    chk("R11 idle after take", req_ready, 1);
    chk("R11 no read in take cycle", rd_cnt - r0, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp("R11");
    chk("R11 held request read", rd_cnt - r0, 1);
    chk("R11 held request pa", rsp_pa, 32'h00444008);
    take_rsp();
  endtask

  task automatic t_base_latch();
    poke(ent_addr(32'h100, 32'h6001), mk_pte(20'h00666, 1, 1, 1));
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h00006001; req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    table_base = 32'h400;
    wait_rsp("R10");
    chk("R10 read addr uses old base", last_rd_addr, 32'h130);
    chk("R10 pa", rsp_pa, 32'h00666001);
    take_rsp();
    table_base = 32'h100;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_page_fault_retry();
    t_protection();
    t_dirty_wb();
    t_hold_and_overlap();
    t_base_latch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule